// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

This block is a single-port synchronous memory. Every rising clock edge can carry a read, a write or a deselect, and a read can follow a write, or a write a read, with no idle cycle between them. Address, command and byte-lane enables are taken on the edge that carries the command. The write data for that command comes later on the data input. It arrives two edges later in the registered-output mode and one edge later in the flow-through mode. Pending writes wait in a short address pipeline. A registered read that hits a pending write gets that write's bytes forwarded, so it never sees stale array contents.

A command may start a four-beat burst. On each following edge where the advance input is high, the next address is produced in linear or interleaved order, and the stored command type is repeated. Storage is arranged as 9-bit byte lanes. Each lane checks the parity of its write data against a selectable even or odd rule. The output enable input is asynchronous and blanks the read data at once.

Top module: `nbt_sram`

## Requirements
- R1: While reset is held and right after it is released, `dq_en` and `par_err` are 0.
- R2: A non-advance edge issues a command only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: nothing is written and no read data is driven for that slot.
- R3: The data for a write issued at edge N is taken from `wdata` at edge N+2 when `pipe_mode`=1, and at edge N+1 when `pipe_mode`=0.
- R4: For a read issued at edge N, `dq_en` is high with the data in the cycle right after edge N when `pipe_mode`=0, and in the cycle right after edge N+1 when `pipe_mode`=1.
- R5: `bw_n[i]`=0 writes lane i, which is `wdata[9i+8:9i]`. Lanes with `bw_n[i]`=1 keep their old contents.
- R6: With `ilv_mode`=0, beat k of a burst (k=0..3) uses address low bits (start + k) mod 4. The upper address bits stay at the start value.
- R7: With `ilv_mode`=1, beat k uses address low bits (start XOR k). The upper address bits stay at the start value.
- R8: In `pipe_mode`=1, a read issued one edge after a write to the same address returns that write's new bytes in its enabled lanes and the array contents in the other lanes.
- R9: Reads and writes may be issued on consecutive edges in any mix. Every read returns the contents left by all writes issued before it.
- R10: `par_err` is high for one cycle after the edge that takes a write's data, when some enabled lane's 9 bits have an XOR that differs from `par_odd` (0: even parity, 1: odd parity). Otherwise it is 0. Disabled lanes are never checked.
- R11: `oe_n`=1 forces `dq_en` to 0 and `rdata` to 0 at once, without waiting for a clock edge.
- R12: With `adv`=1, `ce*`, `we_n` and `addr` are ignored. The last command type continues, and the beat count wraps modulo 4 past the fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Static: 1 registered output with two-edge write lag, 0 flow-through with one-edge lag |
| ilv_mode | input | 1 | Static: 1 interleaved burst order, 0 linear |
| par_odd | input | 1 | Static: 1 odd parity expected per lane, 0 even |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 advances the current burst instead of taking a new command |
| we_n | input | 1 | 0 write, 1 read |
| bw_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*BYTE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANES*BYTE_W | Read data, 0 when not driven |
| dq_en | output | 1 | High while read data is driven |
| par_err | output | 1 | Write parity error flag |

## Verification
The bench runs every combination of output mode, burst order and parity sense. In each one it sends a dense pseudo-random stream over eight addresses, so reads often land one or two edges after a write to the same word. These hits separate a correct forwarding path from one that returns stale data, and a correct write lag from one that is off by one. Bursts of four and of six beats, standalone advance edges and junk control values during advance show whether the beat arithmetic, the wrap and the ignore rule are right for each order. Deselects with each single disabling chip enable, random lane masks, random parity and output-enable pulses both between and inside cycles cover the select decode, the lane merge, the parity rule and the asynchronous blanking.

// File: rtl/nbt_sram_pkg.sv
`timescale 1ns/1ps
package nbt_sram_pkg;

  typedef enum logic { ORD_LINEAR = 1'b0, ORD_XOR = 1'b1 } burst_order_e;

  // Low address bits for a burst beat; upper bits are held by the caller.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input burst_order_e ord);
    return (ord == ORD_XOR) ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/nbt_burst_ctl.sv
`timescale 1ns/1ps
module nbt_burst_ctl #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ilv_mode,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              op_v,
  output logic              op_w,
  output logic [ADDR_W-1:0] op_a,
  output logic [LANES-1:0]  op_be
);
  import nbt_sram_pkg::*;

  logic              sel;
  logic              b_v, b_w;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt, cnt_nx;
  burst_order_e      ord;

  assign sel    = !ce1_n && ce2 && !ce3_n;
  assign cnt_nx = b_cnt + 2'd1;
  assign ord    = burst_order_e'(ilv_mode);
  assign op_be  = ~bw_n;

  always_comb begin
    if (!adv) begin
      op_v = sel;
      op_w = !we_n;
      op_a = addr;
    end else begin
      op_v = b_v;
      op_w = b_w;
      op_a = {b_base[ADDR_W-1:2], beat_low(b_base[1:0], cnt_nx, ord)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_v    <= 1'b0;
      b_w    <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (!adv) begin
      b_v    <= sel;
      b_w    <= !we_n;
      b_base <= addr;
      b_cnt  <= '0;
    end else begin
      b_cnt  <= cnt_nx;
    end
  end

endmodule

// File: rtl/nbt_write_queue.sv
`timescale 1ns/1ps
module nbt_write_queue #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              par_odd,
  input  logic              op_v,
  input  logic              op_w,
  input  logic [ADDR_W-1:0] op_a,
  input  logic [LANES-1:0]  op_be,
  input  logic [DATA_W-1:0] wdata,
  output logic              cm_v,
  output logic [ADDR_W-1:0] cm_a,
  output logic [LANES-1:0]  cm_be,
  output logic              par_err
);

  typedef struct packed {
    logic              v;
    logic [ADDR_W-1:0] a;
    logic [LANES-1:0]  be;
  } slot_t;

  slot_t            s1, s2, due;
  logic [LANES-1:0] lane_err;

  function automatic logic ones_odd(input logic [BYTE_W-1:0] x);
    return ^x;
  endfunction

  assign due   = pipe_mode ? s2 : s1;
  assign cm_v  = due.v;
  assign cm_a  = due.a;
  assign cm_be = due.be;

  for (genvar g = 0; g < LANES; g++) begin : g_par
    assign lane_err[g] = cm_be[g] && (ones_odd(wdata[g*BYTE_W +: BYTE_W]) != par_odd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= '0;
      s2      <= '0;
      par_err <= 1'b0;
    end else begin
      s1      <= '{v: op_v && op_w, a: op_a, be: op_be};
      s2      <= s1;
      par_err <= cm_v && (|lane_err);
    end
  end

endmodule

// File: rtl/nbt_store.sv
`timescale 1ns/1ps
module nbt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              op_v,
  input  logic              op_w,
  input  logic [ADDR_W-1:0] op_a,
  input  logic              cm_v,
  input  logic [ADDR_W-1:0] cm_a,
  input  logic [LANES-1:0]  cm_be,
  input  logic [DATA_W-1:0] wdata,
  output logic              out_v,
  output logic [DATA_W-1:0] out_d,
  output logic              fwd_hit
);

  logic              rd_v, oreg_v;
  logic [ADDR_W-1:0] rd_a;
  logic [DATA_W-1:0] rd_word, fwd_word, oreg_d;

  assign fwd_hit = rd_v && cm_v && (cm_a == rd_a);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (cm_v && cm_be[g]) lane_mem[cm_a] <= wdata[g*BYTE_W +: BYTE_W];
    end
    assign rd_word[g*BYTE_W +: BYTE_W]  = lane_mem[rd_a];
    assign fwd_word[g*BYTE_W +: BYTE_W] = (fwd_hit && cm_be[g]) ?
                                          wdata[g*BYTE_W +: BYTE_W] : lane_mem[rd_a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v   <= 1'b0;
      rd_a   <= '0;
      oreg_v <= 1'b0;
      oreg_d <= '0;
    end else begin
      rd_v   <= op_v && !op_w;
      rd_a   <= op_a;
      oreg_v <= rd_v;
      oreg_d <= fwd_word;
    end
  end

  assign out_v = pipe_mode ? oreg_v : rd_v;
  assign out_d = pipe_mode ? oreg_d : rd_word;

endmodule

// File: rtl/nbt_sram.sv
`timescale 1ns/1ps
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              ilv_mode,
  input  logic              par_odd,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              dq_en,
  output logic              par_err
);

  logic              op_v, op_w;
  logic [ADDR_W-1:0] op_a;
  logic [LANES-1:0]  op_be;
  logic              cm_v;
  logic [ADDR_W-1:0] cm_a;
  logic [LANES-1:0]  cm_be;
  logic              out_v, fwd_hit;
  logic [DATA_W-1:0] out_d;

  nbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .addr(addr),
    .op_v(op_v), .op_w(op_w), .op_a(op_a), .op_be(op_be)
  );

  nbt_write_queue #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_wq (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .par_odd(par_odd),
    .op_v(op_v), .op_w(op_w), .op_a(op_a), .op_be(op_be), .wdata(wdata),
    .cm_v(cm_v), .cm_a(cm_a), .cm_be(cm_be), .par_err(par_err)
  );

  nbt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .op_v(op_v), .op_w(op_w), .op_a(op_a),
    .cm_v(cm_v), .cm_a(cm_a), .cm_be(cm_be), .wdata(wdata),
    .out_v(out_v), .out_d(out_d), .fwd_hit(fwd_hit)
  );

  // Output enable is combinational: blanks the bus without a clock.
  assign dq_en = out_v && !oe_n;
  assign rdata = dq_en ? out_d : '0;

endmodule

// File: rtl/nbt_sram_chk.sv
`timescale 1ns/1ps
module nbt_sram_chk #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 9,
  localparam int DATA_W = LANES * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              ce1_n,
  input logic              ce2,
  input logic              ce3_n,
  input logic              adv,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] rdata,
  input logic              dq_en,
  input logic              par_err,
  input logic              cm_v
);

  logic sel, rd_cmd, wr_cmd, desel;
  assign sel    = !ce1_n && ce2 && !ce3_n;
  assign rd_cmd = !adv && sel && we_n;
  assign wr_cmd = !adv && sel && !we_n;
  assign desel  = !adv && !sel;

  p_oe_blanks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_en && rdata == '0));

  p_flow_read_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_cmd) |=> (dq_en || oe_n));

  p_pipe_read_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_cmd) |=> ##1 (dq_en || oe_n));

  p_desel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && desel) |=> !dq_en);

  p_flow_write_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && wr_cmd) |=> cm_v);

  p_pipe_write_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && wr_cmd) |=> ##1 cm_v);

  p_par_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_v |=> !par_err);

endmodule

bind nbt_sram nbt_sram_chk #(.LANES(LANES), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
  .oe_n(oe_n), .rdata(rdata), .dq_en(dq_en), .par_err(par_err), .cm_v(cm_v)
);

// File: tb/nbt_sram_tb_top.sv
`timescale 1ns/1ps
module nbt_sram_tb_top;
  localparam int ADDR_W = 6;
  localparam int LANES  = 2;
  localparam int BYTE_W = 9;
  localparam int DATA_W = 18;
  localparam int NOPS   = 128;
  localparam int NE     = NOPS + 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n, pipe_mode, ilv_mode, par_odd;
  logic              ce1_n, ce2, ce3_n, adv, we_n, oe_n;
  logic [LANES-1:0]  bw_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              dq_en, par_err;

  nbt_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .ilv_mode(ilv_mode),
    .par_odd(par_odd), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv),
    .we_n(we_n), .bw_n(bw_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .dq_en(dq_en), .par_err(par_err)
  );

  // Stimulus program
  logic              p_adv [NOPS];
  logic [2:0]        p_ce  [NOPS];   // {ce1_n, ce2, ce3_n}
  logic              p_we_n[NOPS];
  logic [LANES-1:0]  p_bw_n[NOPS];
  logic [ADDR_W-1:0] p_addr[NOPS];
  logic [DATA_W-1:0] p_wd  [NOPS];
  logic              p_oe_n[NOPS];
  // Effective operations and expectations per edge
  logic              e_v [NE];
  logic              e_w [NE];
  logic              x_rv[NE];
  logic [DATA_W-1:0] x_rd[NE];
  logic              x_pe[NE];
  string             x_tag[NE];
  logic [DATA_W-1:0] mm [64];

  int n_cmp, n_bad;
  int unsigned seed;
  bit finished;

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic build();
    int burst_left = 0;
    for (int c = 0; c < NOPS; c++) begin
      int unsigned k;
      p_adv[c] = 1'b0; p_ce[c] = 3'b010; p_we_n[c] = 1'b1;
      p_bw_n[c] = 2'b00; p_addr[c] = ADDR_W'(rnd() % 8);
      p_wd[c] = DATA_W'(rnd()); p_oe_n[c] = 1'b0;
      if (c < 8) begin
        p_we_n[c] = 1'b0; p_addr[c] = ADDR_W'(c);
      end else begin
        p_oe_n[c] = (rnd() % 12 == 0);
        if (burst_left > 0) begin
          // R12: junk control during advance must be ignored
          p_adv[c] = 1'b1; p_ce[c] = 3'(rnd()); p_we_n[c] = 1'(rnd());
          p_addr[c] = ADDR_W'(rnd()); p_bw_n[c] = 2'(rnd());
          burst_left--;
        end else begin
          k = rnd() % 16;
          if (k < 2) begin
            case (rnd() % 3)
              0: p_ce[c] = 3'b110;
              1: p_ce[c] = 3'b000;
              default: p_ce[c] = 3'b011;
            endcase
            p_we_n[c] = 1'(rnd());
          end else if (k < 7) begin
            p_we_n[c] = 1'b0; p_bw_n[c] = 2'(rnd());
          end else if (k < 12) begin
            p_we_n[c] = 1'b1;
          end else if (k < 14) begin
            p_we_n[c] = 1'(rnd()); p_bw_n[c] = 2'(rnd());
            burst_left = (rnd() % 4 == 0) ? 5 : 3;
          end else begin
            p_adv[c] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic model();
    logic mv = 1'b0, mw = 1'b0;
    int mbase = 0, mbeat = 0, msince = 0;
    int lat_w = pipe_mode ? 2 : 1;
    int lat_r = pipe_mode ? 1 : 0;
    int ea_prev = -1;
    logic ew_prev = 1'b0;
    for (int e = 0; e < NE; e++) begin
      e_v[e] = 1'b0; e_w[e] = 1'b0; x_rv[e] = 1'b0; x_rd[e] = '0;
      x_pe[e] = 1'b0; x_tag[e] = "R4";
    end
    for (int c = 0; c < NOPS; c++) begin
      int ea;
      if (!p_adv[c]) begin
        mv = (p_ce[c] == 3'b010); mw = !p_we_n[c];
        mbase = int'(p_addr[c]); mbeat = 0; msince = 0; ea = mbase;
      end else begin
        int low;
        mbeat = (mbeat + 1) % 4; msince++;
        if (ilv_mode) low = (mbase % 4) ^ mbeat;
        else low = (mbase % 4 + mbeat) % 4;
        ea = (mbase / 4) * 4 + low;
      end
      e_v[c] = mv; e_w[c] = mw;
      if (!mv) x_tag[c + lat_r] = "R2";
      if (mv && mw) begin
        bit bad = 0;
        for (int g = 0; g < LANES; g++) begin
          logic [BYTE_W-1:0] ln = p_wd[c][g*BYTE_W +: BYTE_W];
          if (!p_bw_n[c][g]) begin
            mm[ea][g*BYTE_W +: BYTE_W] = ln;
            if (($countones(ln) % 2) != int'(par_odd)) bad = 1;
          end
        end
        x_pe[c + lat_w] = bad;
      end
      if (mv && !mw) begin
        int e = c + lat_r;
        x_rv[e] = 1'b1; x_rd[e] = mm[ea];
        if (p_oe_n[c] && 0) x_tag[e] = "R11";
        else if (pipe_mode && ew_prev && ea_prev == ea) x_tag[e] = "R8";
        else if (p_adv[c] && msince >= 4) x_tag[e] = "R12";
        else if (p_adv[c]) x_tag[e] = ilv_mode ? "R7" : "R6";
        else if (ew_prev) x_tag[e] = "R9";
        else if (c > 0 && e_w[c-1]) x_tag[e] = "R3";
        else x_tag[e] = "R5";
      end
      ea_prev = (mv) ? ea : -1; ew_prev = mv && mw;
    end
  endtask

  task automatic run_cfg(input bit pm, input bit im, input bit po);
    int lat_w;
    pipe_mode = pm; ilv_mode = im; par_odd = po;
    lat_w = pm ? 2 : 1;
    adv = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; we_n = 1'b1;
    bw_n = '1; addr = '0; wdata = '0; oe_n = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R1", "dq_en in reset", 32'(dq_en), 0);
    cmp("R1", "par_err in reset", 32'(par_err), 0);
    rst_n = 1'b1;
    build();
    model();
    cmp("R1", "dq_en after reset", 32'(dq_en), 0);
    cmp("R1", "par_err after reset", 32'(par_err), 0);
    for (int c = 0; c < NE; c++) begin
      logic cur_oe;
      if (c < NOPS) begin
        adv = p_adv[c]; {ce1_n, ce2, ce3_n} = p_ce[c]; we_n = p_we_n[c];
        bw_n = p_bw_n[c]; addr = p_addr[c]; oe_n = p_oe_n[c];
      end else begin
        adv = 1'b0; {ce1_n, ce2, ce3_n} = 3'b110; we_n = 1'b1; oe_n = 1'b0;
      end
      cur_oe = oe_n;
      // R3: data lags its write address by the mode's lag
      if (c >= lat_w && e_v[c-lat_w] && e_w[c-lat_w]) wdata = p_wd[c-lat_w];
      else wdata = DATA_W'(c * 1237);
      @(posedge clk);
      @(negedge clk);
      cmp(cur_oe && x_rv[c] ? "R11" : x_tag[c], "dq_en",
          32'(dq_en), 32'(x_rv[c] && !cur_oe));
      cmp(cur_oe && x_rv[c] ? "R11" : x_tag[c], "rdata",
          32'(rdata), (x_rv[c] && !cur_oe) ? 32'(x_rd[c]) : 0);
      cmp("R10", "par_err", 32'(par_err), 32'(x_pe[c]));
      if (x_rv[c] && !cur_oe && (c % 5 == 0)) begin
        // R11: asynchronous blanking in mid-cycle
        oe_n = 1'b1; #0.5;
        cmp("R11", "dq_en async", 32'(dq_en), 0);
        cmp("R11", "rdata async", 32'(rdata), 0);
        oe_n = 1'b0; #0.2;
      end
    end
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; seed = 32'h5eed1234; finished = 0;
    rst_n = 1'b0;
    for (int m = 0; m < 8; m++) run_cfg(m[0], m[1], m[2]);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule